// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide register interface that sits in front of a bank of interval counters. A 2-bit address selects one of the counters' data ports (0 up to NUM_CH-1) or the shared control port (3). Writes to the control port program a channel's access mode, counting mode and BCD flag, freeze a channel's count with a latch command, or issue a read-back command that can freeze count and status of several channels at once. Writes to a data port assemble a 16-bit initial count byte by byte and hand it to the channel with a one-cycle load strobe.

Reads are combinational: `rdata_o` always shows the byte that the addressed port would return, and a cycle with `rd_i` high consumes that byte, advancing the port's sequencing at the clock edge. A pending latched status wins over a pending latched count, which wins over the live count supplied by the counter datapath. The counter datapath is outside this block: it supplies its live count and OUT level and receives loads, mode and BCD.

Top module: `tmr_port_ctrl`

## Requirements
- R1: After reset every channel has access mode low-then-high byte (3), mode 0, BCD 0, both byte toggles at the first byte, no pending latch, and `load_o` low.
- R2: A control-port write whose bits 7:6 name a channel (0..NUM_CH-1) and whose bits 5:4 are non-zero sets that channel's access mode from bits 5:4, mode from bits 3:1 (values 6 and 7 become 2 and 3) and BCD from bit 0, visible on `mode_o`/`bcd_o` from the next cycle; it also returns both toggles to the first byte and discards any pending latched count.
- R3: A data-port write loads the count per access mode: mode 1 loads {8'h00, byte}; mode 2 loads {byte, 8'h00}; mode 3 holds the first byte and loads {second, first} on the second, the toggle then expecting a low byte again. `load_o` pulses for one cycle, the cycle after the completing write, with `load_val_o` valid.
- R4: A control write with bits 5:4 = 0 captures the channel's live count at that write; later reads return it per the access mode at capture time (1: low byte, 2: high byte, 3: low then high) and the latch is released after its last byte.
- R5: A count latch request for a channel that still holds an unread latched count is ignored.
- R6: A control write with bits 7:6 = 3 is a read-back: bits 1, 2, 3 select channels 0, 1, 2; bit 5 low requests a count latch and bit 4 low a status latch, for every selected channel in the same cycle.
- R7: The latched status byte is {OUT, 0, access mode[1:0], mode[2:0], BCD}, taken at the read-back write; a status request is ignored while an unread status is pending.
- R8: A data-port read returns the pending status first and clears it; otherwise a pending latched count; otherwise the live count.
- R9: Live reads return the low byte in access mode 1, the high byte in mode 2, and in mode 3 alternate low then high, starting low.
- R10: The control port reads as 8'h00 and a read there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Port select: data ports 0..NUM_CH-1, control port 3 |
| wr_i | input | 1 | Write strobe for `wdata_i` |
| rd_i | input | 1 | Read consume strobe |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Byte returned by the addressed port |
| live_cnt_i | input | 16*NUM_CH | Live count per channel |
| out_i | input | NUM_CH | OUT level per channel |
| load_o | output | NUM_CH | One-cycle load strobe per channel |
| load_val_o | output | 16*NUM_CH | Count to load per channel |
| mode_o | output | 3*NUM_CH | Counting mode per channel |
| bcd_o | output | NUM_CH | BCD flag per channel |

## Verification
The bench builds the block with its default NUM_CH of 3, so all three read-back select bits map onto real channels and a single read-back can freeze count and status of every channel together. With three channels the random stream interleaves latches, programming and byte-wise reads on different ports, so a pending latch on one channel must survive traffic on the others. Directed cases cover mode folding of 6 and 7, ignored repeat latches, status-before-count ordering and control-port reads that must not disturb a pending status.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  // access mode; ACC_LATCH doubles as "no latched count" for the count latch kind
  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/tmr_cmd_dec.sv
module tmr_cmd_dec #(
  parameter int NUM_CH = 3
) (
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [NUM_CH-1:0] prog_o,
  output logic [NUM_CH-1:0] cnt_latch_o,
  output logic [NUM_CH-1:0] sts_latch_o,
  output logic [NUM_CH-1:0] data_wr_o,
  output logic [NUM_CH-1:0] data_rd_o
);
  logic ctl_wr, rb_cmd, latch_cmd;
  assign ctl_wr    = wr_i && (addr_i == 2'd3);
  assign rb_cmd    = ctl_wr && (wdata_i[7:6] == 2'd3);
  assign latch_cmd = ctl_wr && (wdata_i[5:4] == 2'd0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel            = ctl_wr && (wdata_i[7:6] == 2'(i));
    assign prog_o[i]      = sel && !latch_cmd;
    assign cnt_latch_o[i] = (sel && latch_cmd) || (rb_cmd && wdata_i[1+i] && !wdata_i[5]);
    assign sts_latch_o[i] = rb_cmd && wdata_i[1+i] && !wdata_i[4];
    assign data_wr_o[i]   = wr_i && (addr_i == 2'(i));
    assign data_rd_o[i]   = rd_i && (addr_i == 2'(i));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_i,
  input  logic             cnt_latch_i,
  input  logic             sts_latch_i,
  input  logic             data_wr_i,
  input  logic             data_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] live_cnt_i,
  input  logic             out_i,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [2:0]       mode_o,
  output logic             bcd_o
);
  acc_e              acc_q, lat_kind_q;
  logic [2:0]        mode_q;
  logic              bcd_q, wr_hi_q, rd_hi_q, sts_pend_q, load_q;
  logic [BYTE_W-1:0] hold_q, sts_val_q;
  logic [CNT_W-1:0]  lat_val_q, load_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= ACC_WORD;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      hold_q     <= '0;
      lat_kind_q <= ACC_LATCH;
      lat_val_q  <= '0;
      sts_pend_q <= 1'b0;
      sts_val_q  <= '0;
      load_q     <= 1'b0;
      load_val_q <= '0;
    end else begin
      load_q <= 1'b0;
      if (prog_i) begin
        acc_q      <= acc_e'(wdata_i[5:4]);
        mode_q     <= fold_mode(wdata_i[3:1]);
        bcd_q      <= wdata_i[0];
        wr_hi_q    <= 1'b0;
        rd_hi_q    <= 1'b0;
        lat_kind_q <= ACC_LATCH;
      end
      if (cnt_latch_i && lat_kind_q == ACC_LATCH) begin
        lat_kind_q <= acc_q;
        lat_val_q  <= live_cnt_i;
      end
      if (sts_latch_i && !sts_pend_q) begin
        sts_pend_q <= 1'b1;
        sts_val_q  <= {out_i, 1'b0, acc_q, mode_q, bcd_q};
      end
      if (data_wr_i) begin
        unique case (acc_q)
          ACC_LO: begin
            load_q     <= 1'b1;
            load_val_q <= {8'h00, wdata_i};
          end
          ACC_HI: begin
            load_q     <= 1'b1;
            load_val_q <= {wdata_i, 8'h00};
          end
          ACC_WORD: begin
            if (!wr_hi_q) begin
              hold_q  <= wdata_i;
              wr_hi_q <= 1'b1;
            end else begin
              load_q     <= 1'b1;
              load_val_q <= {wdata_i, hold_q};
              wr_hi_q    <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (data_rd_i) begin
        if (sts_pend_q) sts_pend_q <= 1'b0;
        else if (lat_kind_q != ACC_LATCH)
          lat_kind_q <= (lat_kind_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
        else if (acc_q == ACC_WORD) rd_hi_q <= !rd_hi_q;
      end
    end
  end

  always_comb begin
    if (sts_pend_q) rd_byte_o = sts_val_q;
    else if (lat_kind_q != ACC_LATCH)
      rd_byte_o = (lat_kind_q == ACC_HI) ? lat_val_q[15:8] : lat_val_q[7:0];
    else begin
      unique case (acc_q)
        ACC_HI:   rd_byte_o = live_cnt_i[15:8];
        ACC_WORD: rd_byte_o = rd_hi_q ? live_cnt_i[15:8] : live_cnt_i[7:0];
        default:  rd_byte_o = live_cnt_i[7:0];
      endcase
    end
  end

  assign load_o     = load_q;
  assign load_val_o = load_val_q;
  assign mode_o     = mode_q;
  assign bcd_o      = bcd_q;

  p_load_from_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(data_wr_i));
  p_word_second_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && acc_q == ACC_WORD && wr_hi_q && !prog_i)
      |=> (load_o && load_val_o[15:8] == $past(wdata_i)));
  p_latch_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_latch_i && lat_kind_q != ACC_LATCH && !data_rd_i) |=> $stable(lat_val_q));
  p_status_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && sts_pend_q && !prog_i && !cnt_latch_i) |=> $stable(lat_kind_q));
  p_prog_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> (lat_kind_q == ACC_LATCH && !wr_hi_q && !rd_hi_q));
  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_o[2] && mode_o[1]));
endmodule

// File: rtl/tmr_port_ctrl.sv
module tmr_port_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              addr_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  input  logic [NUM_CH*CNT_W-1:0] live_cnt_i,
  input  logic [NUM_CH-1:0]       out_i,
  output logic [NUM_CH-1:0]       load_o,
  output logic [NUM_CH*CNT_W-1:0] load_val_o,
  output logic [NUM_CH*3-1:0]     mode_o,
  output logic [NUM_CH-1:0]       bcd_o
);
  logic [NUM_CH-1:0] prog, cnt_latch, sts_latch, data_wr, data_rd;
  logic [BYTE_W-1:0] rd_byte [NUM_CH];

  tmr_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .wdata_i     (wdata_i),
    .prog_o      (prog),
    .cnt_latch_o (cnt_latch),
    .sts_latch_o (sts_latch),
    .data_wr_o   (data_wr),
    .data_rd_o   (data_rd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    tmr_chan_regs u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .prog_i      (prog[i]),
      .cnt_latch_i (cnt_latch[i]),
      .sts_latch_i (sts_latch[i]),
      .data_wr_i   (data_wr[i]),
      .data_rd_i   (data_rd[i]),
      .wdata_i     (wdata_i),
      .live_cnt_i  (live_cnt_i[i*CNT_W +: CNT_W]),
      .out_i       (out_i[i]),
      .rd_byte_o   (rd_byte[i]),
      .load_o      (load_o[i]),
      .load_val_o  (load_val_o[i*CNT_W +: CNT_W]),
      .mode_o      (mode_o[i*3 +: 3]),
      .bcd_o       (bcd_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr_i == 2'(i)) rdata_o = rd_byte[i];
  end
endmodule

// File: tb/tb_tmr_port_ctrl.sv
module tb_tmr_port_ctrl;
  localparam int NCH = 3;
  logic clk = 0, rst_ni = 0;
  logic [1:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic [NCH*16-1:0] live_v = 0, load_val;
  logic [NCH-1:0] outv = 0, load, bcd;
  logic [NCH*3-1:0] mode;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  tmr_port_ctrl #(.NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .live_cnt_i(live_v), .out_i(outv),
    .load_o(load), .load_val_o(load_val), .mode_o(mode), .bcd_o(bcd));

  // reference model
  logic [1:0]  m_acc [NCH];
  logic [2:0]  m_mode[NCH];
  logic        m_bcd [NCH], m_wrhi[NCH], m_rdhi[NCH], m_sp[NCH];
  logic [7:0]  m_hold[NCH], m_sts[NCH];
  logic [1:0]  m_kind[NCH];
  logic [15:0] m_lat [NCH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] fold(input logic [2:0] m);
    return (m > 3'd5) ? m - 3'd4 : m;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_acc[i] = 2'd3; m_mode[i] = 0; m_bcd[i] = 0; m_wrhi[i] = 0; m_rdhi[i] = 0;
      m_sp[i] = 0; m_hold[i] = 0; m_sts[i] = 0; m_kind[i] = 0; m_lat[i] = 0;
    end
  endtask

  task automatic m_latch_cnt(input int i);
    if (m_kind[i] == 0) begin m_kind[i] = m_acc[i]; m_lat[i] = live_v[i*16 +: 16]; end
  endtask

  task automatic check_cfg(input string req);
    for (int i = 0; i < NCH; i++) begin
      chk(mode[i*3 +: 3] == m_mode[i], req, mode[i*3 +: 3], m_mode[i]);
      chk(bcd[i] == m_bcd[i], req, bcd[i], m_bcd[i]);
    end
  endtask

  task automatic wr_op(input logic [1:0] a, input logic [7:0] d, input string req);
    logic [NCH-1:0] eload = 0;
    logic [15:0] eval [NCH];
    for (int i = 0; i < NCH; i++) eval[i] = 0;
    if (a == 2'd3) begin
      if (d[7:6] == 2'd3) begin
        for (int i = 0; i < NCH; i++) if (d[1+i]) begin
          if (!d[5]) m_latch_cnt(i);
          if (!d[4] && !m_sp[i]) begin
            m_sp[i] = 1; m_sts[i] = {outv[i], 1'b0, m_acc[i], m_mode[i], m_bcd[i]};
          end
        end
      end else if (d[5:4] == 0) m_latch_cnt(int'(d[7:6]));
      else begin
        int c = int'(d[7:6]);
        m_acc[c] = d[5:4]; m_mode[c] = fold(d[3:1]); m_bcd[c] = d[0];
        m_wrhi[c] = 0; m_rdhi[c] = 0; m_kind[c] = 0;
      end
    end else begin
      int c = int'(a);
      case (m_acc[c])
        2'd1: begin eload[c] = 1; eval[c] = {8'h00, d}; end
        2'd2: begin eload[c] = 1; eval[c] = {d, 8'h00}; end
        default: if (!m_wrhi[c]) begin m_hold[c] = d; m_wrhi[c] = 1; end
                 else begin eload[c] = 1; eval[c] = {d, m_hold[c]}; m_wrhi[c] = 0; end
      endcase
    end
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
    chk(load == eload, req, load, eload);
    for (int i = 0; i < NCH; i++)
      if (eload[i]) chk(load_val[i*16 +: 16] == eval[i], req, load_val[i*16 +: 16], eval[i]);
    check_cfg("R2");
  endtask

  task automatic rd_op(input logic [1:0] a, input string req);
    logic [7:0] e;
    if (a == 2'd3) e = 0;
    else begin
      int c = int'(a);
      logic [15:0] lv = live_v[c*16 +: 16];
      if (m_sp[c]) begin e = m_sts[c]; m_sp[c] = 0; end
      else if (m_kind[c] != 0) begin
        e = (m_kind[c] == 2'd2) ? m_lat[c][15:8] : m_lat[c][7:0];
        m_kind[c] = (m_kind[c] == 2'd3) ? 2'd2 : 2'd0;
      end else begin
        case (m_acc[c])
          2'd2: e = lv[15:8];
          2'd3: begin e = m_rdhi[c] ? lv[15:8] : lv[7:0]; m_rdhi[c] = !m_rdhi[c]; end
          default: e = lv[7:0];
        endcase
      end
    end
    @(negedge clk); addr = a; rd = 1;
    #1 chk(rdata == e, req, rdata, e);
    @(negedge clk); rd = 0;
  endtask

  task automatic set_live(input int c, input logic [15:0] v);
    live_v[c*16 +: 16] = v;
  endtask

  bit done = 0;
  initial begin
    #(2_000_000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1: reset state
    chk(load == 0, "R1", load, 0);
    check_cfg("R1");
    set_live(0, 16'hA55A);
    rd_op(0, "R1"); rd_op(0, "R9");                  // R9: word mode low then high
    // R2: mode 7 folds to 3, access LSB only
    wr_op(3, 8'b00_01_111_1, "R2");
    wr_op(0, 8'h3C, "R3");
    set_live(0, 16'h1234); rd_op(0, "R9");
    // R3: MSB only on ch1
    wr_op(3, 8'b01_10_110_0, "R2");
    wr_op(1, 8'h7E, "R3");
    // R3: word write on ch2
    wr_op(3, 8'b10_11_010_0, "R2");
    wr_op(2, 8'h11, "R3"); wr_op(2, 8'h22, "R3");
    // R4/R5: latch, second latch ignored
    set_live(2, 16'hBEEF); wr_op(3, 8'b10_00_0000, "R4");
    set_live(2, 16'h0F0F); wr_op(3, 8'b10_00_0000, "R5");
    rd_op(2, "R4"); rd_op(2, "R5");
    rd_op(2, "R9");
    // R6/R7/R8: read-back count+status on ch0 and ch1
    outv = 3'b010; set_live(0, 16'h5678); set_live(1, 16'h9ABC);
    wr_op(3, 8'b11_00_0110, "R6");
    outv = 3'b101;
    wr_op(3, 8'b11_10_0010, "R7");                   // status again ignored
    rd_op(3, "R10"); rd_op(3, "R10");
    rd_op(0, "R7"); rd_op(0, "R8"); rd_op(1, "R8"); rd_op(1, "R6");
    // R2: programming discards a pending latch
    set_live(2, 16'hCAFE); wr_op(3, 8'b10_00_0000, "R4");
    wr_op(3, 8'b10_11_000_0, "R2");
    set_live(2, 16'h4321); rd_op(2, "R2"); rd_op(2, "R2");
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int op = int'($urandom_range(0, 9));
      for (int c = 0; c < NCH; c++) set_live(c, 16'($urandom));
      outv = NCH'($urandom);
      case (op)
        0: wr_op(3, {2'($urandom_range(0, 2)), 2'($urandom_range(1, 3)), 4'($urandom)}, "R2");
        1: wr_op(3, {2'($urandom_range(0, 2)), 2'b00, 4'($urandom)}, "R4");
        2: wr_op(3, {2'b11, 6'($urandom)}, "R6");
        3, 4: wr_op(2'($urandom_range(0, 2)), 8'($urandom), "R3");
        default: rd_op(2'($urandom_range(0, 3)), "R8");
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule